// File: doc/BRIEF.md
# Systolic Matrix Multiplier

This block multiplies two square N-by-N matrices of signed W-bit integers on a grid of multiply-accumulate cells. A start pulse captures both operand matrices from flat input buses. An internal skew controller then injects row r of A at the left edge, delayed r cycles, and column c of B at the top edge, delayed c cycles. Zeros fill every slot outside those windows. Each cycle, A values move one cell to the right and B values move one cell down, and each cell adds the product of the pair it sees into its own accumulator. Cell (r,c) ends up holding C[r][c].

When the last product is in, the accumulators shift toward the left edge one column per cycle. The leftmost column appears on the result bus with a valid flag. A whole run takes 4N-2 cycles from the first injection to the last result column. A done pulse marks the final column, and a new start can be accepted in that same cycle, so runs can follow each other with no gap.

Top module: `mm_systolic_top`

## Requirements
- R1: After reset, and whenever no run is in progress, resValid and done are low.
- R2: Call the clock edge that accepts start E0. Row r, column c of a matrix on aMat or bMat sits at bits (r*N+c)*W upward. Result row r on resCol sits at bits r*AW upward, with AW = 2*W + clog2(N). On the k-th valid cycle of a run (k counted from 0), resCol holds column k of C = A x B, so columns appear in order 0, 1, ..., N-1.
- R3: resValid first goes high right after edge E(3N-2), that is, in run step 3N-2 when step 0 is the cycle after E0.
- R4: resValid stays high for exactly N consecutive cycles per run.
- R5: done is high for a single cycle. That cycle is step 4N-3, which is the 4N-2th step of the run and the cycle of the last valid column.
- R6: A start pulse that arrives while a run is in progress, in any step except the last, is ignored. The schedule and the results of the current run are unchanged.
- R7: Operands are two's-complement signed. Each accumulator is AW bits wide, so sums of N products of the most negative value are exact.
- R8: A start accepted in the done cycle begins a new run at once. Its accumulators start from zero and carry nothing from the previous run.
- R9: aMat and bMat are sampled only at the accepting edge. Changing them during a run has no effect on that run's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; captures aMat and bMat |
| aMat | input | N*N*W | Left operand matrix, row-major, signed elements |
| bMat | input | N*N*W | Right operand matrix, row-major, signed elements |
| resCol | output | N*AW | One column of the product, row r at bits r*AW |
| resValid | output | 1 | resCol holds a product column |
| done | output | 1 | Last result column of the run |

## Verification
The hardest cases to reach from the ports are a start arriving in the done cycle itself and a start pulse or operand change landing partway through a run. Both depend on cycle-exact placement relative to the internal step count. The bench drives every run through a task that walks the run step by step at falling edges. That task can raise start or scramble the operand buses at a chosen step index. Random and directed matrix pairs are chained back to back, including a run of all most-negative values followed at once by a small one, so that leftover accumulator state or a missed clear would show up in the next run's columns.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef struct packed {
    logic clr;    // capture operands, zero accumulators and pipes
    logic calc;   // multiply-accumulate step
    logic shift;  // move accumulators one column toward the output
  } strobes_t;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
  parameter int N  = 4,
  parameter int SW = $clog2(4 * N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output mm_pkg::strobes_t  strb,
  output logic [SW-1:0]     step,
  output logic              resValid,
  output logic              done
);
  localparam logic [SW-1:0] LAST_S = SW'(4 * N - 3);
  localparam logic [SW-1:0] CALC_S = SW'(3 * N - 2);

  logic busy;
  logic accept;
  logic atLast;

  assign atLast   = busy && (step == LAST_S);
  assign accept   = start && (!busy || atLast);

  assign strb.clr   = accept;
  assign strb.calc  = busy && (step < CALC_S);
  assign strb.shift = busy && (step >= CALC_S);
  assign resValid   = busy && (step >= CALC_S);
  assign done       = atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (atLast) begin
      busy <= 1'b0;
      step <= '0;
    end else if (busy) begin
      step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
  parameter int W  = 8,
  parameter int AW = 18
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mm_pkg::strobes_t        strb,
  input  logic signed [W-1:0]     aIn,
  input  logic signed [W-1:0]     bIn,
  input  logic signed [AW-1:0]    shIn,
  output logic signed [AW-1:0]    acc
);
  logic signed [2*W-1:0] prod;
  logic signed [AW-1:0]  prodX;

  assign prod  = aIn * bIn;
  assign prodX = AW'(prod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            acc <= '0;
    else if (strb.clr)    acc <= '0;
    else if (strb.calc)   acc <= acc + prodX;
    else if (strb.shift)  acc <= shIn;
  end
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int AW = 18,
  parameter int SW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  mm_pkg::strobes_t   strb,
  input  logic [SW-1:0]      step,
  input  logic [N*N*W-1:0]   aMat,
  input  logic [N*N*W-1:0]   bMat,
  output logic [N*AW-1:0]    resCol
);
  logic signed [W-1:0]  aCap  [N][N];
  logic signed [W-1:0]  bCap  [N][N];
  logic signed [W-1:0]  pipeA [N][N];  // value entering cell (r,c) from the left
  logic signed [W-1:0]  pipeB [N][N];  // value entering cell (r,c) from above
  logic signed [W-1:0]  nextA [N];
  logic signed [W-1:0]  nextB [N];
  logic signed [AW-1:0] accW  [N][N];

  // Skew controller: operand for the coming step, zero outside the window
  always_comb begin
    for (int r = 0; r < N; r++) begin
      nextA[r] = '0;
      nextB[r] = '0;
      for (int k = 0; k < N; k++) begin
        if (strb.calc && (int'(step) + 1 == r + k)) begin
          nextA[r] = aCap[r][k];
          nextB[r] = bCap[k][r];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          aCap[r][c]  <= '0;
          bCap[r][c]  <= '0;
          pipeA[r][c] <= '0;
          pipeB[r][c] <= '0;
        end
    end else if (strb.clr) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          aCap[r][c]  <= aMat[(r*N+c)*W +: W];
          bCap[r][c]  <= bMat[(r*N+c)*W +: W];
          pipeA[r][c] <= '0;
          pipeB[r][c] <= '0;
        end
      pipeA[0][0] <= aMat[W-1:0];
      pipeB[0][0] <= bMat[W-1:0];
    end else if (strb.calc) begin
      for (int r = 0; r < N; r++) begin
        pipeA[r][0] <= nextA[r];
        pipeB[0][r] <= nextB[r];
        for (int c = 1; c < N; c++) begin
          pipeA[r][c] <= pipeA[r][c-1];
          pipeB[c][r] <= pipeB[c-1][r];
        end
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [AW-1:0] shIn;
      if (c == N - 1) begin : g_edge
        assign shIn = '0;
      end else begin : g_inner
        assign shIn = accW[r][c+1];
      end
      mm_pe #(.W(W), .AW(AW)) pe (
        .clk  (clk),
        .rstN (rstN),
        .strb (strb),
        .aIn  (pipeA[r][c]),
        .bIn  (pipeB[r][c]),
        .shIn (shIn),
        .acc  (accW[r][c])
      );
    end
    assign resCol[r*AW +: AW] = accW[r][0];
  end
endmodule

// File: rtl/mm_systolic_top.sv
module mm_systolic_top #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int AW = 2 * W + $clog2(N),
  localparam int SW = $clog2(4 * N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [N*N*W-1:0]   aMat,
  input  logic [N*N*W-1:0]   bMat,
  output logic [N*AW-1:0]    resCol,
  output logic               resValid,
  output logic               done
);
  mm_pkg::strobes_t strb;
  logic [SW-1:0]    step;

  mm_ctrl #(.N(N), .SW(SW)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .strb     (strb),
    .step     (step),
    .resValid (resValid),
    .done     (done)
  );

  mm_datapath #(.N(N), .W(W), .AW(AW), .SW(SW)) dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .step   (step),
    .aMat   (aMat),
    .bMat   (bMat),
    .resCol (resCol)
  );
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic resValid,
  input logic done
);
  logic        runOn;
  logic [15:0] since;
  logic [15:0] vRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runOn <= 1'b0;
      since <= '0;
      vRun  <= '0;
    end else begin
      if (start && (!runOn || done)) begin
        runOn <= 1'b1;
        since <= '0;
      end else if (done) begin
        runOn <= 1'b0;
      end else if (runOn) begin
        since <= since + 1'b1;
      end
      vRun <= resValid ? vRun + 1'b1 : '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runOn |-> (!resValid && !done));

  // R3
  first_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> (since == 16'(3 * N - 2)));

  // R4
  valid_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (vRun < 16'(N)));

  // R5
  done_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resValid && vRun == 16'(N - 1)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind mm_systolic_top mm_chk #(.N(N)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .resValid (resValid),
  .done     (done)
);

// File: tb/tb_mm_systolic_top.sv
module tb_mm_systolic_top;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 2 * W + $clog2(N);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [N*N*W-1:0] aMat = '0;
  logic [N*N*W-1:0] bMat = '0;
  logic [N*AW-1:0]  resCol;
  logic             resValid;
  logic             done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int am [N][N];
  int bm [N][N];
  int cm [N][N];

  always #4 clk = ~clk;

  mm_systolic_top #(.N(N), .W(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .aMat(aMat), .bMat(bMat),
    .resCol(resCol), .resValid(resValid), .done(done)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N*N*W-1:0] packM(input int m [N][N]);
    logic [N*N*W-1:0] v = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        v[(r*N+c)*W +: W] = W'(m[r][c]);
    return v;
  endfunction

  function automatic logic [N*N*W-1:0] junk();
    logic [N*N*W-1:0] v;
    for (int i = 0; i < N * N * W; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  function automatic void refMul();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        cm[r][c] = 0;
        for (int k = 0; k < N; k++) cm[r][c] += am[r][k] * bm[k][c];
      end
  endfunction

  function automatic void randFill();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        am[r][c] = int'($urandom_range(255)) - 128;
        bm[r][c] = int'($urandom_range(255)) - 128;
      end
  endfunction

  function automatic void constFill(int av, int bv);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        am[r][c] = av;
        bm[r][c] = bv;
      end
  endfunction

  // Called at a falling edge; returns at the falling edge inside the done step.
  task automatic runOne(string req, int pokeStep, int scrStep);
    int vSeen = 0;
    aMat  = packM(am);
    bMat  = packM(bm);
    refMul();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 4 * N - 2; t++) begin
      bit expV = (t >= 3 * N - 2);
      bit expD = (t == 4 * N - 3);
      start = (t == pokeStep);
      if (t == scrStep) begin
        aMat = junk();
        bMat = junk();
      end
      // R3 R4: valid window placement
      check(resValid == expV, {req, " R3 valid schedule"}, int'(resValid), int'(expV));
      // R5: done in the last step only
      check(done == expD, {req, " R5 done timing"}, int'(done), int'(expD));
      if (resValid) vSeen++;
      if (expV && resValid) begin
        for (int r = 0; r < N; r++) begin
          int act = int'($signed(resCol[r*AW +: AW]));
          // R2: column t-(3N-2) of the product
          check(act == cm[r][t-(3*N-2)], {req, " R2 product element"}, act, cm[r][t-(3*N-2)]);
        end
      end
      if (t < 4 * N - 3) @(negedge clk);
    end
    start = 1'b0;
    // R4: exactly N valid cycles
    check(vSeen == N, {req, " R4 valid count"}, vSeen, N);
  endtask

  task automatic idleCheck(int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      // R1: quiet while idle
      check(!resValid && !done, "R1 idle outputs", int'({resValid, done}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check(!resValid && !done, "R1 reset state", int'({resValid, done}), 0);
    rstN = 1'b1;
    idleCheck(3);

    // R2: identity times random
    randFill();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) am[r][c] = (r == c) ? 1 : 0;
    runOne("identity", -1, -1);
    idleCheck(2);

    // R7: extreme negative operands, then R8 back-to-back with small values
    constFill(-128, -128);
    runOne("R7 extreme", -1, -1);
    constFill(1, 2);
    runOne("R8 back-to-back", -1, -1);
    constFill(-128, 127);
    runOne("R7 mixed extreme", -1, -1);
    idleCheck(2);

    // Random runs, chained
    for (int n = 0; n < 8; n++) begin
      randFill();
      runOne("random", -1, -1);
    end
    idleCheck(2);

    // R6: start pulses inside a run are ignored
    randFill();
    runOne("R6 early poke", 1, -1);
    idleCheck(1);
    randFill();
    runOne("R6 mid poke", 3 * N - 2, -1);
    idleCheck(1);
    randFill();
    runOne("R6 late poke", 4 * N - 4, -1);
    idleCheck(2);

    // R9: operand buses scrambled mid-run
    randFill();
    runOne("R9 scramble early", -1, 0);
    randFill();
    runOne("R9 scramble late", -1, 2 * N);
    idleCheck(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule